// File: doc/BRIEF.md
# Processor Interrupt Pin Front-End

This block sits between a group of asynchronous processor input pins and the core's exception logic. Each pin passes through a synchronizer. A change detector then compares the synchronized level with the last level it accepted for that pin. An action is taken only when an assigned pin actually changes, so a pin held steady never produces a repeated event.

Different pins have different kinds of response. Five pins are level-sensitive interrupt sources. The machine-check pin fires on its falling edge and its pending bit stays set. The checkstop pin halts the core. The hard-reset pin emits a one-cycle core reset request. The block registers all of its outputs: a pending-source vector, a combined interrupt request, a halted flag and a reset request. An acknowledge input clears the sticky machine-check bit and the halted flag.

Top module: `pin_irq_frontend`

## Requirements
- R1: After reset, pend_o, irq_o, halted_o and rst_req_o are all 0 and every stored pin level is 0.
- R2: A pin change becomes visible at the outputs on the third rising clock edge after the change. Two edges are spent in the synchronizer and one in the action register. Before that edge the outputs keep their old values.
- R3: If the synchronized level of an assigned pin equals its stored level, no action is taken: pend_o and halted_o hold and rst_req_o stays 0.
- R4: The level pins are mapped to pend_o as follows, each active high with its bit following the pin: pin 0 external to bit 0, pin 1 critical to bit 1, pin 2 system-management to bit 2, pin 3 debug to bit 3, pin 4 soft reset to bit 4.
- R5: Pin 5 (machine check) sets pend_o[5] only on a falling edge (stored level 1, new level 0). A rising edge neither sets nor clears that bit.
- R6: irq_o is 1 exactly when at least one bit of pend_o is 1.
- R7: A rising change on pin 7 (hard reset) produces a rst_req_o pulse exactly one cycle long.
- R8: A rising change on pin 6 (checkstop) sets halted_o. With HALT_LATCH=1, halted_o then stays set until ack_i or reset, even if the pin falls.
- R9: With HALT_LATCH=0, a falling change on pin 6 clears halted_o.
- R10: A one-cycle ack_i clears pend_o[5] and halted_o on the next clock edge.
- R11: Pins 8 and above have no function. Changing them alters no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Asynchronous processor input pins |
| ack_i | input | 1 | Clears the sticky machine-check bit and the halted flag |
| pend_o | output | 6 | Pending interrupt sources (bits 0..4 level sources, bit 5 machine check) |
| irq_o | output | 1 | Combined interrupt request |
| halted_o | output | 1 | Core halted by checkstop |
| rst_req_o | output | 1 | One-cycle core reset request |

## Verification
Two groups of directed patterns come first.
- Single-pin toggles on each function class. These separate level-following behaviour from edge-only behaviour: a machine-check rise must leave its bit alone, while an external-pin fall must clear its bit.
- Repeated identical pin words and toggles on the unassigned pins only. These show the change filter at work, because no output may move.

Fixed-seed random pin words then exercise several simultaneous changes. In this phase the latching and releasing checkstop variants run side by side on the same stimulus, which exposes any difference in how the halt is released. Acknowledge pulses are placed between random words so that a sticky bit can later be set again.

// File: rtl/pinfe_pkg.sv
package pinfe_pkg;
  // functional pin positions (fixed: the action decoder depends on them)
  localparam int PIN_EXT   = 0;
  localparam int PIN_CRIT  = 1;
  localparam int PIN_SMI   = 2;
  localparam int PIN_DBG   = 3;
  localparam int PIN_SRST  = 4;
  localparam int PIN_MCHK  = 5;
  localparam int PIN_CSTOP = 6;
  localparam int PIN_HRST  = 7;
  localparam int NUM_FUNC_PINS = 8;
  // pending vector layout
  localparam int NUM_LEVEL_SRC = 5;
  localparam int SRC_MCHK      = 5;
  localparam int NUM_SRC       = 6;
endpackage

// File: rtl/pinfe_sync.sv
module pinfe_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinfe_change.sv
module pinfe_change #(
  parameter int W = 10,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] last_o
);
  logic [W-1:0] last_q;

  // only assigned pins can register a change or update their stored level
  assign chg_o = (lvl_i ^ last_q) & MASK;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= (last_q & ~chg_o) | (lvl_i & chg_o);
  end

  assign last_o = last_q;
endmodule

// File: rtl/pinfe_action.sv
module pinfe_action
  import pinfe_pkg::*;
#(
  parameter bit HALT_LATCH = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_FUNC_PINS-1:0] lvl_i,
  input  logic [NUM_FUNC_PINS-1:0] chg_i,
  input  logic                     ack_i,
  output logic [NUM_SRC-1:0]       pend_o,
  output logic                     irq_o,
  output logic                     halted_o,
  output logic                     rst_req_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic halt_q, halt_d, irq_q, rreq_q, rreq_d;

  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < NUM_LEVEL_SRC; i++) begin
      if (chg_i[i]) pend_d[i] = lvl_i[i];
    end
    if (ack_i) pend_d[SRC_MCHK] = 1'b0;
    if (chg_i[PIN_MCHK] && !lvl_i[PIN_MCHK]) pend_d[SRC_MCHK] = 1'b1;

    halt_d = halt_q;
    if (ack_i) halt_d = 1'b0;
    if (chg_i[PIN_CSTOP]) begin
      if (lvl_i[PIN_CSTOP])  halt_d = 1'b1;
      else if (!HALT_LATCH)  halt_d = 1'b0;
    end

    rreq_d = chg_i[PIN_HRST] && lvl_i[PIN_HRST];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
      halt_q <= halt_d;
      rreq_q <= rreq_d;
    end
  end

  assign pend_o    = pend_q;
  assign irq_o     = irq_q;
  assign halted_o  = halt_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/pin_irq_frontend.sv
module pin_irq_frontend
  import pinfe_pkg::*;
#(
  parameter int NUM_PINS    = 10,
  parameter int SYNC_STAGES = 2,
  parameter bit HALT_LATCH  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                ack_i,
  output logic [5:0]          pend_o,
  output logic                irq_o,
  output logic                halted_o,
  output logic                rst_req_o
);
  function automatic logic [NUM_PINS-1:0] func_mask();
    logic [NUM_PINS-1:0] m;
    for (int i = 0; i < NUM_PINS; i++) m[i] = (i < NUM_FUNC_PINS);
    return m;
  endfunction
  localparam logic [NUM_PINS-1:0] ASSIGNED = func_mask();

  logic [NUM_PINS-1:0] sync_lvl, chg, last_q;

  pinfe_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_i), .q_o(sync_lvl)
  );

  pinfe_change #(.W(NUM_PINS), .MASK(ASSIGNED)) u_chg (
    .clk(clk), .rst(rst), .lvl_i(sync_lvl), .chg_o(chg), .last_o(last_q)
  );

  pinfe_action #(.HALT_LATCH(HALT_LATCH)) u_act (
    .clk(clk), .rst(rst),
    .lvl_i(sync_lvl[NUM_FUNC_PINS-1:0]), .chg_i(chg[NUM_FUNC_PINS-1:0]),
    .ack_i(ack_i), .pend_o(pend_o), .irq_o(irq_o),
    .halted_o(halted_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/pin_irq_frontend_chk.sv
module pin_irq_frontend_chk #(
  parameter bit HALT_LATCH = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       ack_i,
  input logic [7:0] sync_lvl,
  input logic [7:0] last_q,
  input logic [5:0] pend_o,
  input logic       irq_o,
  input logic       halted_o,
  input logic       rst_req_o
);
  // R3: no pin difference -> no action in the following cycle
  a_r3_no_change_no_action: assert property (@(posedge clk) disable iff (rst)
    (!ack_i && sync_lvl == last_q) |=> ($stable(pend_o) && $stable(halted_o) && !rst_req_o));

  // R6: combined request matches the pending vector
  a_r6_irq_matches_pend: assert property (@(posedge clk) disable iff (rst)
    irq_o == (pend_o != 6'd0));

  // R5: machine-check bit is sticky without acknowledge
  a_r5_mchk_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend_o[5] && !ack_i) |=> pend_o[5]);

  // R7: reset request never lasts two cycles
  a_r7_rst_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  // R10: acknowledge clears the halt unless a new checkstop rise arrives
  a_r10_ack_clears_halt: assert property (@(posedge clk) disable iff (rst)
    (ack_i && (sync_lvl[6] == last_q[6])) |=> !halted_o);

  generate
    if (HALT_LATCH) begin : g_latch
      // R8: latched halt holds until acknowledge
      a_r8_halt_held: assert property (@(posedge clk) disable iff (rst)
        (halted_o && !ack_i) |=> halted_o);
    end
  endgenerate
endmodule

bind pin_irq_frontend pin_irq_frontend_chk #(.HALT_LATCH(HALT_LATCH)) u_chk (
  .clk(clk), .rst(rst), .ack_i(ack_i),
  .sync_lvl(sync_lvl[7:0]), .last_q(last_q[7:0]),
  .pend_o(pend_o), .irq_o(irq_o), .halted_o(halted_o), .rst_req_o(rst_req_o)
);

// File: tb/pin_irq_frontend_test.sv
`timescale 1ns/1ps
module pin_irq_frontend_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] pins = '0;
  logic ack = 1'b0;
  logic [5:0] pend, pend_r;
  logic irq, irq_r, halted, halted_r, rreq, rreq_r;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [9:0] m_prev = '0;
  logic [5:0] m_pend = '0;
  logic m_hl = 1'b0, m_hr = 1'b0;

  always #2.5 clk = ~clk;

  pin_irq_frontend #(.NUM_PINS(10), .SYNC_STAGES(2), .HALT_LATCH(1'b1)) uut (
    .clk(clk), .rst(rst), .pins_i(pins), .ack_i(ack),
    .pend_o(pend), .irq_o(irq), .halted_o(halted), .rst_req_o(rreq)
  );
  pin_irq_frontend #(.NUM_PINS(10), .SYNC_STAGES(2), .HALT_LATCH(1'b0)) uut_rel (
    .clk(clk), .rst(rst), .pins_i(pins), .ack_i(ack),
    .pend_o(pend_r), .irq_o(irq_r), .halted_o(halted_r), .rst_req_o(rreq_r)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_pend(logic [9:0] pv, logic [9:0] nw, logic [5:0] p);
    logic [5:0] r = p;
    r[4:0] = nw[4:0];
    if (pv[5] && !nw[5]) r[5] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_halt(logic [9:0] pv, logic [9:0] nw, logic h, bit latch);
    if (nw[6] && !pv[6]) return 1'b1;
    if (!nw[6] && pv[6] && !latch) return 1'b0;
    return h;
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " R4 level bits"}, pend[4:0], m_pend[4:0]);
    chk({tag, " R5 machine check"}, pend[5], m_pend[5]);
    chk({tag, " R6 irq"}, irq, |m_pend);
    chk({tag, " R8 halt latch"}, halted, m_hl);
    chk({tag, " R9 halt release"}, halted_r, m_hr);
    chk({tag, " R4 pend release variant"}, pend_r, m_pend);
  endtask

  task automatic step(input logic [9:0] nw, input string tag);
    logic [5:0] ep;
    logic ehl, ehr, erst;
    ep   = exp_pend(m_prev, nw, m_pend);
    ehl  = exp_halt(m_prev, nw, m_hl, 1'b1);
    ehr  = exp_halt(m_prev, nw, m_hr, 1'b0);
    erst = nw[7] && !m_prev[7];
    @(negedge clk) pins = nw;
    repeat (2) @(negedge clk);
    chk({tag, " R2 old value before third edge"}, pend, m_pend);
    @(negedge clk);
    m_pend = ep; m_hl = ehl; m_hr = ehr;
    m_prev = nw & 10'h0FF;
    check_all(tag);
    chk({tag, " R7 reset request"}, rreq, erst);
    @(negedge clk);
    chk({tag, " R7 reset pulse ends"}, rreq, 1'b0);
    chk({tag, " R3 outputs hold"}, pend, m_pend);
  endtask

  task automatic do_ack(input string tag);
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    m_pend[5] = 1'b0; m_hl = 1'b0; m_hr = 1'b0;
    chk({tag, " R10 ack clears mchk"}, pend[5], 1'b0);
    chk({tag, " R10 ack clears halt"}, halted, 1'b0);
    chk({tag, " R10 ack clears halt rel"}, halted_r, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pend after reset", pend, 6'd0);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 halted after reset", halted, 1'b0);
    chk("R1 rst_req after reset", rreq, 1'b0);

    step(10'h001, "external on");
    step(10'h000, "external off");
    step(10'h01E, "crit smi dbg srst");
    step(10'h01E, "R3 repeat word");
    step(10'h020, "mchk rise");           // R5 rise must not set
    step(10'h000, "mchk fall");           // R5 fall sets
    step(10'h020, "mchk rise again");     // R5 rise must not clear
    do_ack("ack mchk");
    step(10'h060, "checkstop on");
    step(10'h020, "checkstop off");       // R8 vs R9
    do_ack("ack halt");
    step(10'h0A0, "hard reset rise");     // R7
    step(10'h020, "hard reset fall");
    step(10'h320, "R11 unassigned high");
    step(10'h020, "R11 unassigned low");

    for (int k = 0; k < 60; k++) begin
      step(10'($urandom), "random");
      if (($urandom % 6) == 0) do_ack("random ack");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule